// File: doc/BRIEF.md
# Triplicated Multiply-Accumulate with Voted Feedback

This block multiplies two unsigned operands and adds the product into a running sum. It is built for logic that may suffer single-event upsets. Three identical lanes each hold a multiplier, an adder and an accumulator register. The three accumulator outputs pass through bitwise majority voters. The voted sum, not the lane's own register, is what each lane adds its next product to.

Because the accumulation loop closes through a voter, a bit flipped in one lane's register is outvoted at once. On the next clock edge that lane reloads from the agreed value, so the error cannot circulate. Each voter forms the bitwise majority (A and B) or (B and C) or (C and A). The multipliers are purely combinational, and the only registers are the accumulators after the adders. There is no scan or cascade path, since no voter could sit on one.

The caller presents operands with a valid strobe. A synchronous clear input zeroes the sum. Per-lane fault-injection masks let a test flip stored accumulator bits on purpose.

Top module: `tmr_mac`

## Requirements
- R1: While the active-low reset is asserted, all three accumulators are zero and the result output reads zero.
- R2: On a clock edge with valid high and clear low, the result becomes the previous result plus op_a times op_b, both operands unsigned.
- R3: On a clock edge with valid and clear both low, the result keeps its value and the operands are ignored.
- R4: On a clock edge with clear high, the result becomes zero whatever valid and the operands are.
- R5: The sum is ACC_W = 2*OP_W + GUARD_W bits wide (20 with the defaults), and it wraps modulo 2^ACC_W on overflow.
- R6: The result is the bitwise majority of the three accumulators. If one lane is corrupted, the result is unaffected. If two lanes carry the same flipped bits, the result shows those flips.
- R7: After a single lane is corrupted, one further clock edge with no injection in that lane restores agreement among all three accumulators.
- R8: On the edge where it is applied, a fault mask for lane k (flip0, flip1 or flip2) is XORed into the value that lane k stores. This includes edges that accumulate or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accumulate op_a*op_b on this edge |
| clear | input | 1 | Synchronously zero the sum; wins over in_valid |
| op_a | input | OP_W | Unsigned multiplicand |
| op_b | input | OP_W | Unsigned multiplier |
| flip0 | input | ACC_W | Fault mask XORed into lane 0's stored value |
| flip1 | input | ACC_W | Fault mask XORed into lane 1's stored value |
| flip2 | input | ACC_W | Fault mask XORed into lane 2's stored value |
| result | output | ACC_W | Voted accumulated sum |

## Verification
The bound checker tests the accumulation rules on every cycle in which at most one lane receives a fault mask. It covers the add-on-valid step with wrap-around, the hold when idle and clear-to-zero. It also checks that the three lanes agree one edge after any cycle with no injection.

Some behaviours are shown only by the bench's scenarios at the ports. One is the repair of a corrupted lane, which the bench shows by corrupting a second lane on the following edge. The others are the visible corruption when two lanes share a flip, the wrap after a long run of large products, and reset asserted in mid-run.

// File: rtl/tmr_mac_pkg.sv
package tmr_mac_pkg;
   // number of redundant lanes; the voters assume exactly three
   localparam int unsigned COPIES = 3;

   function automatic int unsigned acc_width(input int unsigned op_w, input int unsigned guard_w);
      return 2 * op_w + guard_w;
   endfunction
endpackage

// File: rtl/tmr_mac_mult.sv
module tmr_mac_mult #(
   parameter int unsigned OP_W = 8
) (
   input  logic [OP_W-1:0]   mul_a,
   input  logic [OP_W-1:0]   mul_b,
   output logic [2*OP_W-1:0] mul_p
);
   // purely combinational: no input or pipeline registers
   always_comb begin
      mul_p = (2*OP_W)'(mul_a) * (2*OP_W)'(mul_b);
   end
endmodule

// File: rtl/tmr_mac_vote.sv
module tmr_mac_vote #(
   parameter int unsigned W = 20
) (
   input  logic [W-1:0] in_x,
   input  logic [W-1:0] in_y,
   input  logic [W-1:0] in_z,
   output logic [W-1:0] voted
);
   always_comb begin
      voted = (in_x & in_y) | (in_y & in_z) | (in_z & in_x);
   end
endmodule

// File: rtl/tmr_mac_lane.sv
module tmr_mac_lane #(
   parameter int unsigned OP_W  = 8,
   parameter int unsigned ACC_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             zero_en,
   input  logic [OP_W-1:0]  lane_a,
   input  logic [OP_W-1:0]  lane_b,
   input  logic [ACC_W-1:0] sum_fb,
   input  logic [ACC_W-1:0] upset,
   output logic [ACC_W-1:0] sum_q
);
   logic [2*OP_W-1:0] prod;
   logic [ACC_W-1:0]  sum_d;

   tmr_mac_mult #(.OP_W(OP_W)) u_mult (
      .mul_a (lane_a),
      .mul_b (lane_b),
      .mul_p (prod)
   );

   // next value always starts from the voted sum, never from sum_q
   always_comb begin
      if (zero_en)
         sum_d = '0;
      else if (step_en)
         sum_d = sum_fb + ACC_W'(prod);
      else
         sum_d = sum_fb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sum_q <= '0;
      else
         sum_q <= sum_d ^ upset;
   end
endmodule

// File: rtl/tmr_mac.sv
module tmr_mac
   import tmr_mac_pkg::*;
#(
   parameter int unsigned OP_W    = 8,
   parameter int unsigned GUARD_W = 4,
   localparam int unsigned ACC_W  = acc_width(OP_W, GUARD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             clear,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   input  logic [ACC_W-1:0] flip0,
   input  logic [ACC_W-1:0] flip1,
   input  logic [ACC_W-1:0] flip2,
   output logic [ACC_W-1:0] result
);
   if (OP_W < 1) begin : g_bad_op_w
      $error("tmr_mac: OP_W must be at least 1");
   end
   if (GUARD_W > 32) begin : g_bad_guard_w
      $error("tmr_mac: GUARD_W must not exceed 32");
   end

   logic [ACC_W-1:0] acc_q [COPIES];
   logic [ACC_W-1:0] fb    [COPIES];
   logic [ACC_W-1:0] upset [COPIES];

   always_comb begin
      upset[0] = flip0;
      upset[1] = flip1;
      upset[2] = flip2;
   end

   for (genvar k = 0; k < COPIES; k++) begin : g_lane
      // one voter per lane so a transient in a voter hits only its own lane
      tmr_mac_vote #(.W(ACC_W)) u_vote (
         .in_x  (acc_q[0]),
         .in_y  (acc_q[1]),
         .in_z  (acc_q[2]),
         .voted (fb[k])
      );

      tmr_mac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .step_en (in_valid),
         .zero_en (clear),
         .lane_a  (op_a),
         .lane_b  (op_b),
         .sum_fb  (fb[k]),
         .upset   (upset[k]),
         .sum_q   (acc_q[k])
      );
   end

   assign result = fb[0];
endmodule

// File: rtl/tmr_mac_chk.sv
module tmr_mac_chk #(
   parameter int unsigned OP_W  = 8,
   parameter int unsigned ACC_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             clear,
   input logic [OP_W-1:0]  op_a,
   input logic [OP_W-1:0]  op_b,
   input logic [ACC_W-1:0] flip0,
   input logic [ACC_W-1:0] flip1,
   input logic [ACC_W-1:0] flip2,
   input logic [ACC_W-1:0] result,
   input logic [ACC_W-1:0] lane0,
   input logic [ACC_W-1:0] lane1,
   input logic [ACC_W-1:0] lane2
);
   logic [ACC_W-1:0] prod_w;
   logic             few_flips;
   logic             no_flips;

   always_comb begin
      prod_w    = ACC_W'(op_a) * ACC_W'(op_b);
      few_flips = $countones({|flip0, |flip1, |flip2}) <= 1;
      no_flips  = ~(|flip0 | |flip1 | |flip2);
   end

   // R2 R5
   accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !clear && few_flips) |=> result == $past(result) + $past(prod_w));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clear && few_flips) |=> $stable(result));

   // R4
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && few_flips) |=> result == '0);

   // R7
   lanes_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_flips |=> (lane0 == lane1) && (lane1 == lane2));
endmodule

bind tmr_mac tmr_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .clear    (clear),
   .op_a     (op_a),
   .op_b     (op_b),
   .flip0    (flip0),
   .flip1    (flip1),
   .flip2    (flip2),
   .result   (result),
   .lane0    (acc_q[0]),
   .lane1    (acc_q[1]),
   .lane2    (acc_q[2])
);

// File: tb/tmr_mac_bench.sv
module tmr_mac_bench;
   localparam int unsigned OP_W  = 8;
   localparam int unsigned ACC_W = 20;
   localparam int unsigned NVEC  = 10;

   typedef struct packed {
      logic [OP_W-1:0]  a;
      logic [OP_W-1:0]  b;
      logic             v;
      logic             c;
      logic [ACC_W-1:0] exp;
   } vec_t;

   // running from zero after reset
   localparam vec_t TBL [NVEC] = '{
      '{8'd3,   8'd4,   1'b1, 1'b0, 20'd12},     // R2
      '{8'd10,  8'd10,  1'b1, 1'b0, 20'd112},    // R2
      '{8'd255, 8'd255, 1'b0, 1'b0, 20'd112},    // R3 operands ignored
      '{8'd255, 8'd2,   1'b1, 1'b0, 20'd622},    // R2
      '{8'd7,   8'd9,   1'b1, 1'b1, 20'd0},      // R4 clear beats valid
      '{8'd0,   8'd200, 1'b1, 1'b0, 20'd0},      // R2 zero operand
      '{8'd200, 8'd100, 1'b1, 1'b0, 20'd20000},  // R2
      '{8'd1,   8'd1,   1'b0, 1'b1, 20'd0},      // R4 clear alone
      '{8'd255, 8'd255, 1'b1, 1'b0, 20'd65025},  // R2 max product
      '{8'd16,  8'd16,  1'b1, 1'b0, 20'd65281}   // R2
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             clear = 1'b0;
   logic [OP_W-1:0]  op_a = '0;
   logic [OP_W-1:0]  op_b = '0;
   logic [ACC_W-1:0] flip0 = '0;
   logic [ACC_W-1:0] flip1 = '0;
   logic [ACC_W-1:0] flip2 = '0;
   logic [ACC_W-1:0] result;

   int total = 0;
   int bad   = 0;
   logic [ACC_W-1:0] model;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tmr_mac u_tmr_mac (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .clear    (clear),
      .op_a     (op_a),
      .op_b     (op_b),
      .flip0    (flip0),
      .flip1    (flip1),
      .flip2    (flip2),
      .result   (result)
   );

   task automatic check(input string req, input logic [ACC_W-1:0] exp);
      total++;
      if (result !== exp) begin
         bad++;
         $display("FAIL %s: result=%0d expected=%0d", req, result, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                       input logic v, input logic c,
                       input logic [ACC_W-1:0] f0, input logic [ACC_W-1:0] f1,
                       input logic [ACC_W-1:0] f2);
      op_a = a; op_b = b; in_valid = v; clear = c;
      flip0 = f0; flip1 = f1; flip2 = f2;
      @(posedge clk);
      @(negedge clk);
      flip0 = '0; flip1 = '0; flip2 = '0;
      in_valid = 1'b0; clear = 1'b0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: result=%0d expected=finish", result);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         step(TBL[i].a, TBL[i].b, TBL[i].v, TBL[i].c, '0, '0, '0);
         check($sformatf("R2/R3/R4 vector %0d", i), TBL[i].exp);
      end

      // R5 wrap: 17 maximal products overflow 20 bits
      step('0, '0, 1'b0, 1'b1, '0, '0, '0);
      model = '0;
      for (int i = 0; i < 17; i++) begin
         step(8'd255, 8'd255, 1'b1, 1'b0, '0, '0, '0);
         model = model + ACC_W'(65025);
      end
      check("R5 wrap model", model);
      check("R5 wrap value", 20'd56849);

      // R6 single corrupted lane is outvoted
      step(8'd3, 8'd4, 1'b1, 1'b1, '0, '0, '0);
      step(8'd3, 8'd4, 1'b1, 1'b0, '0, '0, '0);
      check("R2 reload", 20'd12);
      step('0, '0, 1'b0, 1'b0, 20'hFFFFF, '0, '0);
      check("R6 one lane flipped", 20'd12);
      // R7 lane 0 must be repaired, otherwise lanes 0 and 1 now outvote lane 2
      step('0, '0, 1'b0, 1'b0, '0, 20'hFFFFF, '0);
      check("R7 lane repaired", 20'd12);
      step('0, '0, 1'b0, 1'b0, '0, '0, 20'hFFFFF);
      check("R7 second repair", 20'd12);

      // R8 flip on an accumulating edge, then another lane on the next
      step(8'd2, 8'd5, 1'b1, 1'b0, '0, '0, 20'h80000);
      check("R8 flip during add", 20'd22);
      step('0, '0, 1'b0, 1'b0, 20'h80000, '0, '0);
      check("R8 follow-up", 20'd22);

      // R8 flip on a clearing edge
      step('0, '0, 1'b0, 1'b1, '0, 20'h00010, '0);
      check("R8 flip during clear", 20'd0);
      step('0, '0, 1'b0, 1'b0, 20'h00010, '0, '0);
      check("R8 clear follow-up", 20'd0);

      // R6 two lanes with the same flip win the vote
      step(8'd1, 8'd5, 1'b1, 1'b0, '0, '0, '0);
      step('0, '0, 1'b0, 1'b0, 20'h00100, 20'h00100, '0);
      check("R6 two lanes flipped", 20'd5 ^ 20'h00100);

      // R1 reset in mid-run
      rst_n = 1'b0;
      #2;
      check("R1 async reset", '0);
      @(negedge clk);
      rst_n = 1'b1;
      step(8'd6, 8'd7, 1'b1, 1'b0, '0, '0, '0);
      check("R2 after reset", 20'd42);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule